// File: doc/BRIEF.md
# ADC Digital Volume Attenuator with Mute

This block scales a stream of signed ADC samples by a gain selected with an 8-bit code. The code sets an attenuation in half-decibel steps. The top code passes samples through at unity. Each lower code takes off another 0.5 dB, down to -127 dB at code 1. Code 0 is a hard mute that forces every output sample to zero.

The code is converted to a linear multiplier in two parts. A 12-entry mantissa table covers one 6 dB octave. A right shift then supplies each further whole octave, with one octave taken as an exact factor of two. Each valid input sample is multiplied by the multiplier. The product is rounded to nearest and clamped to the signed output range.

The result is registered, so the output appears one cycle after the input. The gain code is sampled in the same cycle as the sample it scales. A code change therefore applies from the next valid sample onward, and no output sample is built from two gains.

Top module: `adc_atten`

## Requirements
- R1: With code 255, every output sample equals its input sample exactly (0 dB).
- R2: With code 0, every output sample is 0, whatever the input.
- R3: For code c from 1 to 255, let a = 255 - c, s = a / 12 and i = a mod 12. The multiplier is m = round(32768 * 10^(-i/40)). The output is floor((x*m + 2^(14+s)) / 2^(15+s)), which is x*m / 2^(15+s) rounded to nearest.
- R4: Lowering the code by 12 keeps the same mantissa and halves the result before rounding. For example, x = -32768 gives -16384 at code 243, -8192 at code 231 and -4096 at code 219.
- R5: A result that lies exactly halfway rounds toward positive infinity. At code 243, x = 3 gives 2 and x = -3 gives -1.
- R6: The output never has a larger magnitude than the input it came from, and it always stays within the signed 16-bit range.
- R7: out_valid is high in the cycle after each cycle in which in_valid is high, and low otherwise.
- R8: In a cycle in which in_valid is low, out_sample keeps its previous value.
- R9: While rst_n is low, out_valid and out_sample are 0.
- R10: Each output uses the gain code present in the same cycle as its input sample. Back-to-back samples with different codes are each scaled by their own code.
- R11: Code 1 gives -127 dB. Full-scale input, 32767 or -32768, rounds to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| in_code | input | 8 | Gain code, 0 = mute, 255 = unity |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed scaled output sample |

## Verification
The assertions check on every cycle the properties that do not depend on the exact value of the result:
- the valid strobe follows the input one cycle later;
- the output holds between samples;
- mute gives zero;
- unity code passes the sample through;
- the output never grows in magnitude.

The exact attenuation law, including table accuracy, octave shifts, half-way rounding and the -127 dB floor, can only be shown by the bench. It sweeps all 256 codes against a set of inputs and compares each result with a value computed from powers of ten. Code changes between back-to-back samples are also shown only by bench scenarios.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int FRAC_W        = 15;  // multiplier fraction bits, 1.0 = 2**FRAC_W
  localparam int MANT_W        = FRAC_W + 1;
  localparam int STEPS_PER_OCT = 12;  // half-dB steps per factor of two
  localparam int IDX_W         = $clog2(STEPS_PER_OCT);

  typedef logic [MANT_W-1:0] mant_t;

  // one octave of 10^(-i/40) in unsigned 1.15 fixed point
  function automatic mant_t octave_mant(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    octave_mant = mant_t'(32768);
      4'd1:    octave_mant = mant_t'(30935);
      4'd2:    octave_mant = mant_t'(29205);
      4'd3:    octave_mant = mant_t'(27571);
      4'd4:    octave_mant = mant_t'(26029);
      4'd5:    octave_mant = mant_t'(24573);
      4'd6:    octave_mant = mant_t'(23198);
      4'd7:    octave_mant = mant_t'(21900);
      4'd8:    octave_mant = mant_t'(20675);
      4'd9:    octave_mant = mant_t'(19519);
      4'd10:   octave_mant = mant_t'(18427);
      default: octave_mant = mant_t'(17396);
    endcase
  endfunction

  // arithmetic right shift with round half toward +inf
  function automatic longint round_shift(input longint value, input int amount);
    longint bias;
    bias = longint'(1) <<< (amount - 1);
    round_shift = (value + bias) >>> amount;
  endfunction

  // clamp to a signed range of the given width
  function automatic longint clamp_signed(input longint value, input int width);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (width - 1)) - 1;
    lo = -(longint'(1) <<< (width - 1));
    if (value > hi)      clamp_signed = hi;
    else if (value < lo) clamp_signed = lo;
    else                 clamp_signed = value;
  endfunction
endpackage

// File: rtl/atten_gain_map.sv
module atten_gain_map
  import atten_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int SHIFT_W = 6
) (
  input  logic [CODE_W-1:0]  code,
  output mant_t              mant,
  output logic [SHIFT_W-1:0] shift,
  output logic               mute
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] steps;
  logic [CODE_W-1:0] oct;
  logic [CODE_W-1:0] rem;

  always_comb begin
    steps = CODE_W'(CODE_MAX) - code;
    oct   = steps / CODE_W'(STEPS_PER_OCT);
    rem   = steps % CODE_W'(STEPS_PER_OCT);
    mant  = octave_mant(rem[IDX_W-1:0]);
    shift = SHIFT_W'(oct);
    mute  = (code == '0);
  end
endmodule

// File: rtl/atten_scaler.sv
module atten_scaler
  import atten_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SHIFT_W  = 6
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  mant_t                      mant,
  input  logic [SHIFT_W-1:0]         shift,
  input  logic                       mute,
  output logic signed [SAMPLE_W-1:0] result
);
  longint product;
  longint rounded;
  longint clamped;
  int     total_shift;

  always_comb begin
    product     = longint'(sample) * longint'({1'b0, mant});
    total_shift = FRAC_W + int'(shift);
    rounded     = round_shift(product, total_shift);
    clamped     = clamp_signed(rounded, SAMPLE_W);
    result      = mute ? '0 : SAMPLE_W'(clamped);
  end
endmodule

// File: rtl/adc_atten.sv
module adc_atten
  import atten_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  input  logic [CODE_W-1:0]          in_code,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_sample
);
  localparam int SHIFT_W  = $clog2(((1 << CODE_W) / STEPS_PER_OCT) + 1);
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  mant_t                      gain_mant;
  logic [SHIFT_W-1:0]         gain_shift;
  logic                       gain_mute;
  logic signed [SAMPLE_W-1:0] scaled;
  logic                       sample_take;

  assign sample_take = in_valid;

  atten_gain_map #(.CODE_W(CODE_W), .SHIFT_W(SHIFT_W)) i_map (
    .code (in_code),
    .mant (gain_mant),
    .shift(gain_shift),
    .mute (gain_mute)
  );

  atten_scaler #(.SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W)) i_scale (
    .sample(in_sample),
    .mant  (gain_mant),
    .shift (gain_shift),
    .mute  (gain_mute),
    .result(scaled)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= sample_take;
      if (sample_take) out_sample <= scaled;
    end
  end

  // R7: strobe follows input one cycle later
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == ($past(in_valid) && $past(rst_n)));

  // R8: output held between samples
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample));

  // R2: mute code gives zero
  a_r2_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_code == '0) |=> out_sample == '0);

  // R1: unity code passes sample through
  a_r1_unity: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_code == CODE_W'(CODE_MAX)) |=> out_sample == $past(in_sample));

  // R6: attenuation never increases magnitude
  a_r6_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_sample < 0 ? -longint'(out_sample) : longint'(out_sample)) <=
                  ($past(in_sample) < 0 ? -longint'($past(in_sample)) : longint'($past(in_sample)))));
endmodule

// File: tb/test_adc_atten.sv
module test_adc_atten;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic [7:0]        in_code = '0;
  logic              out_valid;
  logic signed [15:0] out_sample;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  adc_atten i_adc_atten (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_code(in_code), .out_valid(out_valid), .out_sample(out_sample)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected value from the attenuation law in R3
  function automatic longint model(input int code, input int x);
    int     a;
    int     sh;
    int     idx;
    int     t;
    longint m;
    longint p;
    longint r;
    if (code == 0) return 0;
    a   = 255 - code;
    sh  = a / 12;
    idx = a % 12;
    m   = longint'($floor(32768.0 * $pow(10.0, -real'(idx) / 40.0) + 0.5));
    p   = longint'(x) * m;
    t   = 15 + sh;
    r   = (p + (longint'(1) <<< (t - 1))) >>> t;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // one sample in, one idle cycle; check after the capturing edge
  task automatic one(input int code, input int x, input string req);
    in_valid  = 1'b1;
    in_code   = 8'(code);
    in_sample = 16'(x);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, longint'(out_valid), 1);
    chk({req, " value"}, longint'(out_sample), model(code, x));
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vals[12] = '{32767, -32768, 1, -1, 2, -2, 3, -3, 100, -777, 12345, -20001};
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 valid", longint'(out_valid), 0);
    chk("R9 sample", longint'(out_sample), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 idle", longint'(out_valid), 0);

    // R3 sweep over all codes
    for (int c = 0; c < 256; c++)
      for (int k = 0; k < 12; k++)
        one(c, vals[k], "R3 sweep");

    // R1 unity
    one(255, -12345, "R1");
    chk("R1 exact", longint'(out_sample), -12345);
    // R2 mute
    one(0, 32767, "R2");
    chk("R2 zero", longint'(out_sample), 0);
    // R4 octave steps
    one(243, -32768, "R4");
    chk("R4 c243", longint'(out_sample), -16384);
    one(231, -32768, "R4");
    chk("R4 c231", longint'(out_sample), -8192);
    one(219, -32768, "R4");
    chk("R4 c219", longint'(out_sample), -4096);
    // R5 half-way rounding
    one(243, 3, "R5");
    chk("R5 pos", longint'(out_sample), 2);
    one(243, -3, "R5");
    chk("R5 neg", longint'(out_sample), -1);
    // R11 floor
    one(1, 32767, "R11");
    chk("R11 pos", longint'(out_sample), 0);
    one(1, -32768, "R11");
    chk("R11 neg", longint'(out_sample), 0);
    // R6 range
    one(255, -32768, "R6");
    chk("R6 min", longint'(out_sample), -32768);

    // R8 hold over idle cycles
    one(250, 20000, "R8");
    repeat (3) begin
      @(negedge clk);
      chk("R8 strobe", longint'(out_valid), 0);
      chk("R8 hold", longint'(out_sample), model(250, 20000));
    end

    // R10 back-to-back with code change
    in_valid = 1'b1; in_code = 8'd255; in_sample = 16'sd9000;
    @(negedge clk);
    chk("R10 first", longint'(out_sample), 9000);
    chk("R7 first", longint'(out_valid), 1);
    in_code = 8'd0; in_sample = 16'sd9000;
    @(negedge clk);
    chk("R10 second", longint'(out_sample), 0);
    chk("R7 second", longint'(out_valid), 1);
    in_code = 8'd243; in_sample = 16'sd9000;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 third", longint'(out_sample), 4500);
    @(negedge clk);
    chk("R7 drop", longint'(out_valid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule